// File: doc/BRIEF.md
# System Counter Control Frame

This block is the control frame of a free-running 64-bit system counter. It sits on a simple 32-bit register bus with a 4 KiB address window. Software can enable the counter, make it stop while a debug halt is requested, and switch on scaled counting. It can load the 64-bit count in two word writes, read the count back, and keep a table of frequency modes. The count drives the `count_value` port, which feeds the timer frames of the chip.

The counter steps once for each cycle in which `tick` is high, while counting is enabled and not halted. With scaling off the step is 1. With scaling on the step is the integer part of the scale register, which holds a fixed-point value with `SCALE_FRAC` fraction bits (8 by default, so the integer part is bits [31:8]).

A frequency mode is changed through a request field in the control word. The status word shows the new index one cycle after the request, but only if the named table entry exists and is not zero. A table entry that holds zero marks a mode as unavailable.

Top module: `syscnt_ctrl_frame`

## Requirements
- R1: After reset the control word, the status word and the count read zero. Table entry 0 (offset 0x020) reads `BASE_HZ`, which is 0x016E3600 by default. The identification word at 0x01C reads 0x00000001 when `SCALE_IMPL` is 1.
- R2: The control word at 0x000 keeps the enable bit at bit 0, halt-on-debug at bit 1, scaling enable at bit 2 and the mode request at bits [17:8]. All other bits read zero. The status word (0x004) and the identification word ignore writes.
- R3: When enabled and not halted, the count rises by 1 for each cycle with `tick` high and scaling off. It does not change without `tick` or while the enable bit is 0. The carry passes from the low word into the high word.
- R4: With scaling enabled, each tick adds scale[31:8] of the scale register at 0x010 (for example 0x380 gives a step of 3).
- R5: While halt-on-debug is set and `dbg_halt` is high, the count holds and status bit 1 reads 1. With halt-on-debug clear, `dbg_halt` has no effect and status bit 1 reads 0.
- R6: A write to 0x008 only stages the low word and leaves the count unchanged. A write to 0x00C loads the count with {written word, staged low word}. Reads of 0x008 and 0x00C return the low and high count words.
- R7: A request naming a nonzero table entry shows in status bits [17:8] one cycle after the control write, not in the cycle the write lands.
- R8: A request naming a zero table entry, or an index of 40 or more, is ignored, and status bits [17:8] keep the previous index.
- R9: Table entry i is read/write at 0x020 + 4*i for i from 0 to 39. The scale register at 0x010 is read/write.
- R10: Offsets that are not listed, including 0x014, 0x0C0 and 0xFFC, read zero, and writes to them have no effect.
- R11: `count_value` always equals the 64-bit count that the register reads return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 12 | Byte offset inside the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick | input | 1 | Count step enable |
| dbg_halt | input | 1 | Debug halt request |
| count_value | output | 64 | Current count |

## Verification
The assertions take for granted that `bus_wr`, `bus_addr`, `tick` and `dbg_halt` are synchronous to `clk` and free of unknowns after reset. They also assume a new mode request is not written in the cycle right after the previous one, so each request is judged against the table as it stands. The stimulus changes inputs only on falling edges. It leaves at least one idle cycle after every control write. It keeps `tick` low during register traffic, so a tick and a count load never meet by accident.

// File: rtl/syscnt_pkg.sv
package syscnt_pkg;
  localparam int ADDR_W    = 12;
  localparam int WORD_W    = 32;
  localparam int CNT_W     = 64;
  localparam int REQ_W     = 10;
  localparam int REQ_LSB   = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_SCALE  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_IDENT  = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_TABLE  = 12'h020;

  typedef struct packed {
    logic [REQ_W-1:0] req;
    logic             scale_on;
    logic             halt_dbg;
    logic             enable;
  } ctrl_t;
endpackage

// File: rtl/syscnt_counter.sv
module syscnt_counter #(
  parameter int CNT_W      = 64,
  parameter int WORD_W     = 32,
  parameter int SCALE_FRAC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              scale_on,
  input  logic [WORD_W-1:0] scale_val,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [CNT_W-1:0]  count
);
  logic [CNT_W-1:0]  cnt_q, cnt_d, step;
  logic [WORD_W-1:0] lo_q;
  logic              cnt_en;

  assign step   = scale_on ? CNT_W'(scale_val >> SCALE_FRAC) : CNT_W'(1);
  assign cnt_en = hi_wr | (run & tick);

  always_comb begin
    cnt_d = cnt_q;
    if (hi_wr)           cnt_d = {wdata, lo_q};
    else if (run & tick) cnt_d = cnt_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_wr) lo_q <= wdata;
  end

  assign count = cnt_q;

  // R3 R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hi_wr) |=> cnt_q == $past(cnt_q));
  // R6
  hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> cnt_q[CNT_W-1:WORD_W] == $past(wdata));
  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !scale_on && !hi_wr) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/syscnt_freq_table.sv
module syscnt_freq_table #(
  parameter int              NUM_FREQ = 40,
  parameter int              WORD_W   = 32,
  parameter int              REQ_W    = 10,
  parameter logic [31:0]     BASE_HZ  = 32'd24_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_wr,
  input  logic [REQ_W-1:0]  tbl_idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] tbl_rdata,
  input  logic              req_wr,
  input  logic [REQ_W-1:0]  req_idx,
  output logic [REQ_W-1:0]  ack_idx
);
  logic [WORD_W-1:0] tbl_q [NUM_FREQ];
  logic [REQ_W-1:0]  ack_q;
  logic              pend_q;
  logic              hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_FREQ; i++)
        tbl_q[i] <= (i == 0) ? WORD_W'(BASE_HZ) : '0;
    end else if (tbl_wr) begin
      for (int i = 0; i < NUM_FREQ; i++)
        if (tbl_idx == REQ_W'(i)) tbl_q[i] <= wdata;
    end
  end

  always_comb begin
    tbl_rdata = '0;
    hit       = 1'b0;
    for (int i = 0; i < NUM_FREQ; i++) begin
      if (tbl_idx == REQ_W'(i)) tbl_rdata = tbl_q[i];
      if (req_idx == REQ_W'(i) && tbl_q[i] != '0) hit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= req_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ack_q <= '0;
    else if (pend_q & hit) ack_q <= req_idx;
  end

  assign ack_idx = ack_q;

  // R7 R8
  ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q != $past(ack_q)) |-> $past(pend_q));
  // R8
  ack_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q < REQ_W'(NUM_FREQ));
endmodule

// File: rtl/syscnt_ctrl_frame.sv
module syscnt_ctrl_frame
  import syscnt_pkg::*;
#(
  parameter int          NUM_FREQ   = 40,
  parameter int          SCALE_FRAC = 8,
  parameter bit          SCALE_IMPL = 1'b1,
  parameter logic [31:0] BASE_HZ    = 32'd24_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              tick,
  input  logic              dbg_halt,
  output logic [CNT_W-1:0]  count_value
);
  localparam logic [ADDR_W-1:0] TBL_END = OFS_TABLE + ADDR_W'(4 * NUM_FREQ);

  ctrl_t             ctrl_q, ctrl_d;
  logic [WORD_W-1:0] scale_q;
  logic [WORD_W-1:0] tbl_rdata;
  logic [REQ_W-1:0]  ack_idx, tbl_idx;
  logic [CNT_W-1:0]  count;
  logic              in_tbl, halted, run;
  logic              ctrl_wr, scale_wr, lo_wr, hi_wr, tbl_wr;

  assign in_tbl   = (bus_addr >= OFS_TABLE) && (bus_addr < TBL_END);
  assign tbl_idx  = REQ_W'((bus_addr - OFS_TABLE) >> 2);
  assign ctrl_wr  = bus_wr && bus_addr == OFS_CTRL;
  assign scale_wr = bus_wr && bus_addr == OFS_SCALE;
  assign lo_wr    = bus_wr && bus_addr == OFS_CNT_LO;
  assign hi_wr    = bus_wr && bus_addr == OFS_CNT_HI;
  assign tbl_wr   = bus_wr && in_tbl;

  assign halted = ctrl_q.halt_dbg & dbg_halt;
  assign run    = ctrl_q.enable & ~halted;

  always_comb begin
    ctrl_d.enable   = bus_wdata[0];
    ctrl_d.halt_dbg = bus_wdata[1];
    ctrl_d.scale_on = SCALE_IMPL ? bus_wdata[2] : 1'b0;
    ctrl_d.req      = bus_wdata[REQ_LSB +: REQ_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        scale_q <= '0;
    else if (scale_wr) scale_q <= bus_wdata;
  end

  syscnt_counter #(
    .CNT_W(CNT_W), .WORD_W(WORD_W), .SCALE_FRAC(SCALE_FRAC)
  ) i_counter (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .scale_on(ctrl_q.scale_on), .scale_val(scale_q),
    .lo_wr(lo_wr), .hi_wr(hi_wr), .wdata(bus_wdata), .count(count)
  );

  syscnt_freq_table #(
    .NUM_FREQ(NUM_FREQ), .WORD_W(WORD_W), .REQ_W(REQ_W), .BASE_HZ(BASE_HZ)
  ) i_freq_table (
    .clk(clk), .rst_n(rst_n), .tbl_wr(tbl_wr), .tbl_idx(tbl_idx),
    .wdata(bus_wdata), .tbl_rdata(tbl_rdata),
    .req_wr(ctrl_wr), .req_idx(ctrl_q.req), .ack_idx(ack_idx)
  );

  always_comb begin
    bus_rdata = '0;
    if (in_tbl) bus_rdata = tbl_rdata;
    else begin
      case (bus_addr)
        OFS_CTRL:   bus_rdata = WORD_W'({ctrl_q.req, 5'b0, ctrl_q.scale_on,
                                          ctrl_q.halt_dbg, ctrl_q.enable});
        OFS_STAT:   bus_rdata = WORD_W'({ack_idx, 6'b0, halted, 1'b0});
        OFS_CNT_LO: bus_rdata = count[WORD_W-1:0];
        OFS_CNT_HI: bus_rdata = count[CNT_W-1:WORD_W];
        OFS_SCALE:  bus_rdata = scale_q;
        OFS_IDENT:  bus_rdata = WORD_W'(SCALE_IMPL ? 4'b0001 : 4'b0000);
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign count_value = count;
endmodule

// File: tb/test_syscnt_ctrl_frame.sv
`timescale 1ns/1ps
module test_syscnt_ctrl_frame;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick = 1'b0;
  logic        dbg_halt = 1'b0;
  logic [63:0] count_value;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [63:0] exp_cnt;

  always #2.5 clk = ~clk;

  syscnt_ctrl_frame i_syscnt_ctrl_frame (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .dbg_halt(dbg_halt), .count_value(count_value)
  );

  // {addr, write data, expected read-back}
  localparam int NV = 11;
  localparam logic [75:0] VEC [NV] = '{
    {12'h010, 32'h0000_0380, 32'h0000_0380},  // R9 scale
    {12'h024, 32'h0000_1000, 32'h0000_1000},  // R9 entry 1
    {12'h0BC, 32'h0000_1234, 32'h0000_1234},  // R9 entry 39
    {12'h028, 32'h0000_0000, 32'h0000_0000},  // R9 entry 2 zero
    {12'h014, 32'hFFFF_FFFF, 32'h0000_0000},  // R10
    {12'h0C0, 32'hDEAD_BEEF, 32'h0000_0000},  // R10
    {12'hFFC, 32'hFFFF_FFFF, 32'h0000_0000},  // R10
    {12'h004, 32'hFFFF_FFFF, 32'h0000_0000},  // R2 status read-only
    {12'h01C, 32'h0000_0000, 32'h0000_0001},  // R2 ident read-only
    {12'h000, 32'hFFFF_FFF8, 32'h0003_FF00},  // R2 request field only
    {12'h000, 32'h0000_0000, 32'h0000_0000}   // R2
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(12'h000, r); chk("R1 ctrl", 64'(r), 64'h0);
    rd(12'h004, r); chk("R1 status", 64'(r), 64'h0);
    chk("R1 count", count_value, 64'h0);
    rd(12'h020, r); chk("R1 base entry", 64'(r), 64'h016E_3600);
    rd(12'h01C, r); chk("R1 ident", 64'(r), 64'h1);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      @(negedge clk);
      rd(VEC[i][75:64], r);
      chk("R2/R9/R10 vector", 64'(r), 64'(VEC[i][31:0]));
    end

    // R6 split load
    wr(12'h008, 32'h0000_0010);
    chk("R6 low staged only", count_value, 64'h0);
    wr(12'h00C, 32'h0000_0001);
    exp_cnt = 64'h1_0000_0010;
    chk("R6 loaded", count_value, exp_cnt);
    rd(12'h008, r); chk("R6 read low", 64'(r), 64'h10);
    rd(12'h00C, r); chk("R6 read high", 64'(r), 64'h1);

    // R3 counting
    wr(12'h000, 32'h1);
    ticks(5); exp_cnt += 5;
    chk("R3 five ticks", count_value, exp_cnt);
    repeat (3) @(negedge clk);
    chk("R3 no tick", count_value, exp_cnt);
    wr(12'h008, 32'hFFFF_FFFE);
    wr(12'h00C, 32'h0);
    ticks(3); exp_cnt = 64'h1_0000_0001;
    chk("R3 carry", count_value, exp_cnt);
    rd(12'h00C, r); chk("R11 high word", 64'(r), 64'h1);
    wr(12'h000, 32'h0);
    ticks(4);
    chk("R3 disabled", count_value, exp_cnt);

    // R4 scaled step of 3
    wr(12'h000, 32'h5);
    ticks(4); exp_cnt += 12;
    chk("R4 scaled", count_value, exp_cnt);

    // R5 halt on debug
    wr(12'h000, 32'h3);
    dbg_halt = 1'b1;
    ticks(4);
    chk("R5 held", count_value, exp_cnt);
    rd(12'h004, r); chk("R5 status halted", 64'(r & 32'h2), 64'h2);
    wr(12'h000, 32'h1);
    ticks(2); exp_cnt += 2;
    chk("R5 halt bit clear", count_value, exp_cnt);
    rd(12'h004, r); chk("R5 status running", 64'(r & 32'h2), 64'h0);
    dbg_halt = 1'b0;

    // R7 handshake timing
    wr(12'h000, 32'h0000_0100);
    rd(12'h004, r); chk("R7 not yet", 64'(r), 64'h0);
    @(negedge clk);
    rd(12'h004, r); chk("R7 acknowledged", 64'(r), 64'h100);

    // R8 rejected requests
    wr(12'h000, 32'h0000_0200); @(negedge clk);
    rd(12'h004, r); chk("R8 zero entry", 64'(r), 64'h100);
    wr(12'h000, 32'h0000_2D00); @(negedge clk);
    rd(12'h004, r); chk("R8 out of range", 64'(r), 64'h100);
    wr(12'h000, 32'h0000_2700); @(negedge clk);
    rd(12'h004, r); chk("R7 last entry", 64'(r), 64'h2700);

    // R11
    rd(12'h008, r); chk("R11 low word", 64'(r), count_value & 64'hFFFF_FFFF);
    chk("R11 port", count_value, exp_cnt);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule